// File: doc/BRIEF.md
# Filtered Edge-Triggered Non-Maskable Interrupt Input

This block takes one asynchronous non-maskable interrupt pin and turns a chosen transition on it into a sticky interrupt request. The pin first passes through a two-flop synchronizer. The synchronized level then goes either straight to the edge detector or through a three-sample digital noise filter. The filter samples at a divided clock rate chosen by software. The edge detector compares the conditioned level with its value one cycle earlier. When the transition matches the programmed polarity and the interrupt is armed, the detector sets the request flag.

Software reaches the block through a byte-wide port with four addresses. The polarity, filter-enable and sample-rate controls may be changed only before the interrupt is armed. After arming, writes to them are dropped and arming cannot be undone short of reset. The request flag stays set until software clears it with a write-one.

The interrupt sequencer has three states. `IRQ_OFF` goes to `IRQ_ARMED` on an enable write. `IRQ_ARMED` goes to `IRQ_PENDING` on a matching edge. `IRQ_PENDING` returns to `IRQ_ARMED` on a clear write made without a coincident edge. A coincident edge keeps it in `IRQ_PENDING`.

The filter sequencer also has three states. `FLT_STEADY` goes to `FLT_ONE` on a sample that differs from the output. `FLT_ONE` goes to `FLT_TWO` on a second differing sample. `FLT_TWO` returns to `FLT_STEADY`, and the output flips if the third sample also differs. Any agreeing sample returns the sequencer to `FLT_STEADY`.

Top module: `nmi_edge_irq`

## Requirements
- R1: After reset, every register address reads 0x00 and `irq_req` is 0.
- R2: Address 0 holds the polarity control at bit 3 (0 = falling edge, 1 = rising edge). Its other bits read 0 and ignore writes.
- R3: Address 1 bit 0 enables the filter (1 = filtered, 0 = bypass). Address 2 bits [1:0] select the sample rate. All other bits of both addresses read 0 and ignore writes.
- R4: With the filter bypassed and the interrupt armed, `irq_req` is still 0 after the second rising clock edge that follows a matching pin change, and it is 1 after the third.
- R5: Only the transition selected by the polarity bit sets the request. The opposite transition leaves it unchanged.
- R6: With the filter enabled, the conditioned level changes only after three consecutive samples all show the new level. A pulse that spans two samples is rejected.
- R7: Sample-rate encodings 0, 1, 2 and 3 give one sample every 1, 8, 32 and 64 clock cycles.
- R8: Edges seen while the interrupt is not armed never set the request. Address 3 bit 0 reads the arm state and bit 7 reads the request.
- R9: Writing 1 to address 3 bit 0 arms the interrupt. Only reset disarms it; writing 0 has no effect.
- R10: Writing 1 to address 3 bit 1 clears the request. A matching edge in the same cycle wins, and the request stays set.
- R11: While the interrupt is armed, writes to addresses 0, 1 and 2 are ignored.
- R12: While the filter is disabled, its output tracks the synchronized pin. Enabling the filter and then arming therefore produces no spurious request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Raw asynchronous interrupt pin |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Sticky interrupt request flag |

## Verification
The hardest case to reach from the ports is a clear write that lands in exactly the cycle in which the edge detector fires, because the pin reaches the detector two flops late. The bench first leaves a request pending with the pin back at its inactive level. It then drives the pin at a falling clock edge and counts two rising edges before asserting the clear for one cycle. The request is still set afterwards. Filter acceptance is bounded independently of the prescaler phase by pulses of exactly two and four sample periods at each rate.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    typedef enum logic [1:0] {
        IRQ_OFF     = 2'd0,
        IRQ_ARMED   = 2'd1,
        IRQ_PENDING = 2'd2
    } irq_state_t;

    typedef enum logic [1:0] {
        FLT_STEADY = 2'd0,
        FLT_ONE    = 2'd1,
        FLT_TWO    = 2'd2
    } flt_state_t;

    localparam logic [1:0] ADDR_EDGE = 2'd0;
    localparam logic [1:0] ADDR_FILT = 2'd1;
    localparam logic [1:0] ADDR_RATE = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;

    localparam int POL_BIT = 3;
    localparam int FEN_BIT = 0;
    localparam int ARM_BIT = 0;
    localparam int CLR_BIT = 1;
    localparam int REQ_BIT = 7;

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_prescaler.sv
module nmi_prescaler #(
    parameter int DIV_0 = 1,
    parameter int DIV_1 = 8,
    parameter int DIV_2 = 32,
    parameter int DIV_3 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    output logic       strobe
);
    localparam int MAXDIV = (DIV_3 > 2) ? DIV_3 : 2;
    localparam int CW     = $clog2(MAXDIV);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (rate_sel)
            2'd0:    limit = CW'(DIV_0 - 1);
            2'd1:    limit = CW'(DIV_1 - 1);
            2'd2:    limit = CW'(DIV_2 - 1);
            default: limit = CW'(DIV_3 - 1);
        endcase
    end

    assign strobe = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (strobe) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/nmi_filter.sv
module nmi_filter
    import nmi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic strobe,
    input  logic din,
    output logic level
);
    flt_state_t state_q;
    flt_state_t state_d;
    logic       differs;
    logic       flip;

    assign differs = (din != level);

    always_comb begin
        state_d = FLT_STEADY;
        flip    = 1'b0;
        unique case (state_q)
            FLT_STEADY: state_d = differs ? FLT_ONE : FLT_STEADY;
            FLT_ONE:    state_d = differs ? FLT_TWO : FLT_STEADY;
            FLT_TWO: begin
                state_d = FLT_STEADY;
                flip    = differs;
            end
            default:    state_d = FLT_STEADY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
        end else if (!enable) begin
            state_q <= FLT_STEADY;
        end else if (strobe) begin
            state_q <= state_d;
        end
    end

    // output register: tracks the pin while disabled (preload)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= 1'b0;
        end else if (!enable) begin
            level <= din;
        end else if (strobe && flip) begin
            level <= din;
        end
    end
endmodule

// File: rtl/nmi_edge_irq.sv
module nmi_edge_irq
    import nmi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RATE_DIV_0  = 1,
    parameter int RATE_DIV_1  = 8,
    parameter int RATE_DIV_2  = 32,
    parameter int RATE_DIV_3  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nmi_pin,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_req
);
    irq_state_t state_q;
    irq_state_t state_d;

    logic       pol_q;
    logic       fen_q;
    logic [1:0] sel_q;
    logic       sync_lvl;
    logic       flt_lvl;
    logic       strobe;
    logic       cond_lvl;
    logic       prev_q;
    logic       edge_hit;
    logic       irq_en;
    logic       cfg_open;
    logic       ctrl_wr;
    logic       arm_req;
    logic       clr_req;
    logic       unused_wdata;

    assign unused_wdata = ^{bus_wdata[7:4], bus_wdata[2]};

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (nmi_pin),
        .dout  (sync_lvl)
    );

    nmi_prescaler #(
        .DIV_0 (RATE_DIV_0),
        .DIV_1 (RATE_DIV_1),
        .DIV_2 (RATE_DIV_2),
        .DIV_3 (RATE_DIV_3)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (sel_q),
        .strobe   (strobe)
    );

    nmi_filter u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (fen_q),
        .strobe (strobe),
        .din    (sync_lvl),
        .level  (flt_lvl)
    );

    assign cond_lvl = fen_q ? flt_lvl : sync_lvl;
    assign edge_hit = (cond_lvl != prev_q) && (cond_lvl == pol_q);

    assign cfg_open = (state_q == IRQ_OFF);
    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
    assign arm_req  = ctrl_wr && bus_wdata[ARM_BIT];
    assign clr_req  = ctrl_wr && bus_wdata[CLR_BIT];

    // configuration registers, locked once armed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
            fen_q <= 1'b0;
            sel_q <= 2'b00;
        end else if (bus_wr && cfg_open) begin
            unique case (bus_addr)
                ADDR_EDGE: pol_q <= bus_wdata[POL_BIT];
                ADDR_FILT: fen_q <= bus_wdata[FEN_BIT];
                ADDR_RATE: sel_q <= bus_wdata[1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= cond_lvl;
        end
    end

    // interrupt sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_OFF:     if (arm_req) state_d = IRQ_ARMED;
            IRQ_ARMED:   if (edge_hit) state_d = IRQ_PENDING;
            IRQ_PENDING: if (!edge_hit && clr_req) state_d = IRQ_ARMED;
            default:     state_d = IRQ_OFF;
        endcase
    end

    // interrupt sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // interrupt sequencer: outputs
    always_comb begin
        irq_en  = 1'b0;
        irq_req = 1'b0;
        unique case (state_q)
            IRQ_OFF:     ;
            IRQ_ARMED:   irq_en = 1'b1;
            IRQ_PENDING: begin
                irq_en  = 1'b1;
                irq_req = 1'b1;
            end
            default:     ;
        endcase
    end

    always_comb begin
        bus_rdata = 8'h00;
        unique case (bus_addr)
            ADDR_EDGE: bus_rdata[POL_BIT] = pol_q;
            ADDR_FILT: bus_rdata[FEN_BIT] = fen_q;
            ADDR_RATE: bus_rdata[1:0]     = sel_q;
            default: begin
                bus_rdata[ARM_BIT] = irq_en;
                bus_rdata[REQ_BIT] = irq_req;
            end
        endcase
    end
endmodule

// File: rtl/nmi_edge_irq_chk.sv
module nmi_edge_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_en,
    input logic       irq_req,
    input logic       edge_hit,
    input logic       clr_req,
    input logic       pol_q,
    input logic       fen_q,
    input logic [1:0] sel_q,
    input logic       flt_lvl,
    input logic       sync_lvl,
    input logic       strobe
);
    assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && edge_hit) |=> irq_req);

    assert_req_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_en);

    assert_arm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(irq_en) |-> irq_en);

    assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !edge_hit) |=> !irq_req);

    assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(irq_en) |-> ($stable(pol_q) && $stable(fen_q) && $stable(sel_q)));

    assert_filter_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fen_q && $past(fen_q) && (flt_lvl != $past(flt_lvl)))
            |-> ($past(strobe) && ($past(sync_lvl) == flt_lvl)));
endmodule

bind nmi_edge_irq nmi_edge_irq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_en   (irq_en),
    .irq_req  (irq_req),
    .edge_hit (edge_hit),
    .clr_req  (clr_req),
    .pol_q    (pol_q),
    .fen_q    (fen_q),
    .sel_q    (sel_q),
    .flt_lvl  (flt_lvl),
    .sync_lvl (sync_lvl),
    .strobe   (strobe)
);

// File: tb/nmi_edge_irq_test.sv
module nmi_edge_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_req;

    int total = 0;
    int bad = 0;
    logic [7:0] rd;

    always #10 clk = ~clk;

    nmi_edge_irq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_pin   (nmi_pin),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req)
    );

    // {addr[1:0], wdata[7:0], expected read[7:0]}
    localparam logic [17:0] REG_VEC [8] = '{
        {2'd0, 8'hFF, 8'h08},
        {2'd0, 8'h00, 8'h00},
        {2'd1, 8'hFF, 8'h01},
        {2'd1, 8'h00, 8'h00},
        {2'd2, 8'hFF, 8'h03},
        {2'd2, 8'h02, 8'h02},
        {2'd2, 8'h00, 8'h00},
        {2'd3, 8'h00, 8'h00}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = 8'h00;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        nmi_pin = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), rd);
            check(rd == 8'h00, "R1 reset read", rd, 0);
        end
        check(irq_req == 1'b0, "R1 reset irq_req", irq_req, 0);

        // R2 R3: register vector table
        for (int i = 0; i < 8; i++) begin
            bus_write(REG_VEC[i][17:16], REG_VEC[i][15:8]);
            bus_read(REG_VEC[i][17:16], rd);
            check(rd == REG_VEC[i][7:0], "R2 R3 register table", rd, REG_VEC[i][7:0]);
        end

        // R8: edges while unarmed are ignored
        do_reset();
        bus_write(2'd0, 8'h08);
        set_pin(1'b1);
        wait_cyc(5);
        set_pin(1'b0);
        wait_cyc(5);
        set_pin(1'b1);
        wait_cyc(5);
        bus_read(2'd3, rd);
        check(rd == 8'h00, "R8 unarmed edge ignored", rd, 0);
        set_pin(1'b0);
        wait_cyc(5);

        // R9: arm, then writing 0 does not disarm
        bus_write(2'd3, 8'h01);
        bus_write(2'd3, 8'h00);
        bus_read(2'd3, rd);
        check(rd == 8'h01, "R9 arm sticky", rd, 1);

        // R11: config locked while armed
        bus_write(2'd0, 8'h00);
        bus_read(2'd0, rd);
        check(rd == 8'h08, "R11 polarity locked", rd, 8);
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, rd);
        check(rd == 8'h00, "R11 filter enable locked", rd, 0);
        bus_write(2'd2, 8'h03);
        bus_read(2'd2, rd);
        check(rd == 8'h00, "R11 rate locked", rd, 0);

        // R4: bypass latency, rising polarity
        set_pin(1'b1);
        @(negedge clk);
        @(negedge clk);
        check(irq_req == 1'b0, "R4 not yet after two edges", irq_req, 0);
        @(negedge clk);
        check(irq_req == 1'b1, "R4 set after third edge", irq_req, 1);
        bus_read(2'd3, rd);
        check(rd == 8'h81, "R8 status read", rd, 8'h81);

        // R5: opposite edge leaves the flag as is
        set_pin(1'b0);
        wait_cyc(5);
        check(irq_req == 1'b1, "R5 falling ignored keeps flag", irq_req, 1);

        // R10: clear coincident with a matching edge, edge wins
        set_pin(1'b1);
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = 2'd3;
        bus_wdata = 8'h02;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = 8'h00;
        check(irq_req == 1'b1, "R10 edge wins over clear", irq_req, 1);
        bus_write(2'd3, 8'h02);
        check(irq_req == 1'b0, "R10 plain clear", irq_req, 0);

        // R5: falling polarity
        do_reset();
        bus_write(2'd3, 8'h01);
        set_pin(1'b1);
        wait_cyc(5);
        check(irq_req == 1'b0, "R5 rising ignored on falling polarity", irq_req, 0);
        set_pin(1'b0);
        wait_cyc(5);
        check(irq_req == 1'b1, "R5 falling detected", irq_req, 1);

        // R12: filter preload gives no spurious request
        do_reset();
        set_pin(1'b1);
        wait_cyc(4);
        bus_write(2'd0, 8'h08);
        bus_write(2'd1, 8'h01);
        bus_write(2'd2, 8'h03);
        bus_write(2'd3, 8'h01);
        wait_cyc(300);
        check(irq_req == 1'b0, "R12 no spurious edge", irq_req, 0);
        set_pin(1'b0);
        wait_cyc(5);

        // R6 R7: pulses of two and four sample periods at each rate
        for (int s = 0; s < 4; s++) begin
            int d;
            d = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 32 : 64;
            do_reset();
            bus_write(2'd0, 8'h08);
            bus_write(2'd1, 8'h01);
            bus_write(2'd2, 8'(s));
            bus_write(2'd3, 8'h01);
            wait_cyc(4);
            set_pin(1'b1);
            wait_cyc(2 * d - 1);
            set_pin(1'b0);
            wait_cyc(4 * d + 10);
            check(irq_req == 1'b0, "R6 R7 two-sample pulse rejected", irq_req, 0);
            set_pin(1'b1);
            wait_cyc(4 * d - 1);
            set_pin(1'b0);
            wait_cyc(4 * d + 10);
            check(irq_req == 1'b1, "R6 R7 four-sample pulse accepted", irq_req, 1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule